// File: doc/BRIEF.md
# Six-Read Command Sequence Detector

This block sits beside a byte-wide memory array. It watches the host accesses to find a fixed series of six reads that asks for a nonvolatile store or a nonvolatile recall. Each access reaches the block as a single-cycle event on `acc_valid_i`. The event carries a 13-bit address and a write flag, and is qualified by the chip-enable edge upstream. The reads themselves are not held back. The first five return normal array data. Whether the output enable is active plays no part in matching.

The first five addresses of both commands are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order. The sixth address picks the command: 0x0F0F asks for a store and 0x0F0E asks for a recall. When the sixth read is accepted, the block raises a one-cycle request toward the store/recall controller, which then disables the chip for the operation. Any write, or any read of an address that is not the next one expected, throws the partial match away. While the controller is busy, or while writes are inhibited by low supply, the block holds at idle.

Top module: `cmd_seq_detect`

## Requirements
- R1: Six reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order, set `store_req_o` high for the clock cycle that follows the edge that samples the sixth read. The five reads before it raise no request.
- R2: The same five reads followed by a read of 0x0F0E set `recall_req_o` high in the same way.
- R3: Each request is exactly one cycle wide. `store_req_o` and `recall_req_o` are never high together. Neither is high in a cycle that does not follow the sample of a completing read.
- R4: An access with `acc_we_i`=1 aborts any partial match, even when it targets the expected address. A write to 0x0000 does not start a new match.
- R5: A read of any address other than the next expected one aborts the partial match, and no request follows for the rest of that series.
- R6: A read of 0x0000 that aborts a partial match, or that comes as a wrong sixth address, counts as the first step of a new match.
- R7: While `busy_i`=1, sampled accesses are ignored and the match returns to idle. No request is raised, and reads made before the busy period cannot be completed after it.
- R8: `wr_inhibit_i`=1 has the same effect as `busy_i`.
- R9: Cycles with `acc_valid_i`=0 do not change the match, so gaps of any length between steps are allowed.
- R10: While `rst_ni` is low, both request outputs are 0 and the match is idle.
- R11: A sixth read of an address that is neither 0x0F0F nor 0x0F0E gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle access event, qualified by chip enable |
| acc_addr_i | input | 13 | Address of the access |
| acc_we_i | input | 1 | 1 = write access, 0 = read access |
| busy_i | input | 1 | Store or recall operation in progress |
| wr_inhibit_i | input | 1 | Low supply: writes and commands inhibited |
| store_req_o | output | 1 | One-cycle nonvolatile store request |
| recall_req_o | output | 1 | One-cycle nonvolatile recall request |

## Verification
The match state can only be seen at the ports when a series reaches its sixth read. A step counter that skips, resets too late or fails to reset therefore shows up only at the end of the series. It appears as a missing, extra or wrong-polarity request one cycle after that read is sampled. The sequences are built so that each kind of abort (write, wrong read, busy, inhibit, bad sixth address) is followed by the rest of a valid series, which a leaky abort would turn into a request. Every cycle is compared against an expected request of none, store or recall, so a pulse that is too wide or a spurious pulse is caught in the cycle after it appears.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int unsigned ADDR_W  = 13;
  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN);
  localparam int unsigned LAST    = SEQ_LEN - 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_RECALL = 2'd2
  } req_e;

  // ordered key; the last entry is the store variant
  function automatic addr_t key_addr(int unsigned idx);
    case (idx)
      0:       key_addr = 13'h0000;
      1:       key_addr = 13'h1555;
      2:       key_addr = 13'h0AAA;
      3:       key_addr = 13'h1FFF;
      4:       key_addr = 13'h10F0;
      default: key_addr = 13'h0F0F;
    endcase
  endfunction

  localparam addr_t RECALL_LAST = 13'h0F0E;
endpackage

// File: rtl/cmd_addr_match.sv
module cmd_addr_match
  import cmd_seq_pkg::*;
(
  input  addr_t              addr_i,
  output logic [SEQ_LEN-1:0] hit_o,
  output logic               recall_hit_o
);
  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_key
    assign hit_o[i] = (addr_i == key_addr(i));
  end
  assign recall_hit_o = (addr_i == RECALL_LAST);
endmodule

// File: rtl/cmd_step_fsm.sv
module cmd_step_fsm
  import cmd_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic               hold_i,
  input  logic [SEQ_LEN-1:0] hit_i,
  input  logic               recall_hit_i,
  output req_e               cmd_o
);
  step_t step_q, step_d;
  logic  exp_hit;

  always_comb begin
    exp_hit = 1'b0;
    for (int unsigned i = 0; i < SEQ_LEN; i++)
      if (step_q == step_t'(i)) exp_hit = hit_i[i];
  end

  always_comb begin
    step_d = step_q;
    cmd_o  = REQ_NONE;
    if (hold_i) begin
      step_d = '0;
    end else if (valid_i) begin
      if (we_i) begin
        step_d = '0;
      end else if (step_q == step_t'(LAST) && exp_hit) begin
        cmd_o  = REQ_STORE;
        step_d = '0;
      end else if (step_q == step_t'(LAST) && recall_hit_i) begin
        cmd_o  = REQ_RECALL;
        step_d = '0;
      end else if (step_q < step_t'(LAST) && exp_hit) begin
        step_d = step_q + step_t'(1);
      end else begin
        // a stray read of the first key restarts the match
        step_d = hit_i[0] ? step_t'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  a_r9_gap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !hold_i) |=> $stable(step_q));
  a_r7_hold_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (step_q == '0));
  a_r4_write_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i) |=> (step_q == '0));
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= step_t'(LAST));
endmodule

// File: rtl/cmd_req_reg.sv
module cmd_req_reg
  import cmd_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  req_e cmd_i,
  output logic store_o,
  output logic recall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o  <= 1'b0;
      recall_o <= 1'b0;
    end else begin
      store_o  <= (cmd_i == REQ_STORE);
      recall_o <= (cmd_i == REQ_RECALL);
    end
  end

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && recall_o));
  a_r3_store_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);
  a_r3_recall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o);
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_we_i,
  input  logic              busy_i,
  input  logic              wr_inhibit_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  logic [SEQ_LEN-1:0] hit;
  logic               recall_hit;
  logic               hold;
  req_e               cmd;

  assign hold = busy_i | wr_inhibit_i;

  cmd_addr_match u_match (
    .addr_i       (acc_addr_i),
    .hit_o        (hit),
    .recall_hit_o (recall_hit)
  );

  cmd_step_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (acc_valid_i),
    .we_i         (acc_we_i),
    .hold_i       (hold),
    .hit_i        (hit),
    .recall_hit_i (recall_hit),
    .cmd_o        (cmd)
  );

  cmd_req_reg u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .store_o  (store_req_o),
    .recall_o (recall_req_o)
  );

  a_r1_req_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> $past(acc_valid_i && !acc_we_i));
  a_r7_no_req_when_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || wr_inhibit_i) |=> !(store_req_o || recall_req_o));
endmodule

// File: tb/tb_cmd_seq_detect.sv
module tb_cmd_seq_detect;
  import cmd_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [12:0] addr = '0;
  logic        we = 1'b0;
  logic        busy = 1'b0;
  logic        inh = 1'b0;
  logic        store_req, recall_req;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          run_mon = 1'b0;
  req_e        exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cmd_seq_detect dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_valid_i  (valid),
    .acc_addr_i   (addr),
    .acc_we_i     (we),
    .busy_i       (busy),
    .wr_inhibit_i (inh),
    .store_req_o  (store_req),
    .recall_req_o (recall_req)
  );

  function automatic req_e seen();
    if (store_req && recall_req) return req_e'(2'd3);
    if (store_req)  return REQ_STORE;
    if (recall_req) return REQ_RECALL;
    return REQ_NONE;
  endfunction

  // monitor: every cycle is compared, idle cycles expect no request (R3)
  always @(negedge clk) begin
    if (run_mon) begin
      req_e  e;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = REQ_NONE;
        t = "R3";
      end
      n_chk++;
      if (seen() !== e) begin
        n_fail++;
        $display("FAIL %s: got %0d expected %0d at %0t", t, seen(), e, $time);
      end
    end
  end

  task automatic access(input logic [12:0] a, input logic w, input logic b,
                        input logic i, input req_e e, input string t);
    @(negedge clk);
    valid = 1'b1; addr = a; we = w; busy = b; inh = i;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    valid = 1'b0; we = 1'b0; busy = 1'b0; inh = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [12:0] a, input req_e e, input string t);
    access(a, 1'b0, 1'b0, 1'b0, e, t);
  endtask

  task automatic idle(input int n, input logic b, input logic i);
    @(negedge clk);
    busy = b; inh = i;
    repeat (n) @(negedge clk);
    busy = 1'b0; inh = 1'b0;
  endtask

  task automatic prefix5(input string t);
    rd(13'h0000, REQ_NONE, t);
    rd(13'h1555, REQ_NONE, t);
    rd(13'h0AAA, REQ_NONE, t);
    rd(13'h1FFF, REQ_NONE, t);
    rd(13'h10F0, REQ_NONE, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (store_req !== 1'b0 || recall_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: outputs %b%b expected 00 in reset", store_req, recall_req);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_mon = 1'b1;

    // R1 store
    prefix5("R1");
    rd(13'h0F0F, REQ_STORE, "R1");
    // R2 recall, back to back
    prefix5("R2");
    rd(13'h0F0E, REQ_RECALL, "R2");

    // R4 write at the expected third address
    rd(13'h0000, REQ_NONE, "R4");
    rd(13'h1555, REQ_NONE, "R4");
    access(13'h0AAA, 1'b1, 1'b0, 1'b0, REQ_NONE, "R4");
    rd(13'h1FFF, REQ_NONE, "R4");
    rd(13'h10F0, REQ_NONE, "R4");
    rd(13'h0F0F, REQ_NONE, "R4");
    // R4 write to 0x0000 does not restart
    access(13'h0000, 1'b1, 1'b0, 1'b0, REQ_NONE, "R4");
    rd(13'h1555, REQ_NONE, "R4");
    rd(13'h0AAA, REQ_NONE, "R4");
    rd(13'h1FFF, REQ_NONE, "R4");
    rd(13'h10F0, REQ_NONE, "R4");
    rd(13'h0F0F, REQ_NONE, "R4");

    // R5 wrong read in step four
    rd(13'h0000, REQ_NONE, "R5");
    rd(13'h1555, REQ_NONE, "R5");
    rd(13'h0AAA, REQ_NONE, "R5");
    rd(13'h1FFE, REQ_NONE, "R5");
    rd(13'h10F0, REQ_NONE, "R5");
    rd(13'h0F0F, REQ_NONE, "R5");

    // R6 restart on 0x0000 after abort
    rd(13'h0000, REQ_NONE, "R6");
    rd(13'h1555, REQ_NONE, "R6");
    prefix5("R6");
    rd(13'h0F0F, REQ_STORE, "R6");

    // R11 bad sixth address, then 0x0000 as sixth restarts (R6)
    prefix5("R11");
    rd(13'h0F0D, REQ_NONE, "R11");
    prefix5("R11");
    rd(13'h0000, REQ_NONE, "R6");
    rd(13'h1555, REQ_NONE, "R6");
    rd(13'h0AAA, REQ_NONE, "R6");
    rd(13'h1FFF, REQ_NONE, "R6");
    rd(13'h10F0, REQ_NONE, "R6");
    rd(13'h0F0E, REQ_RECALL, "R6");

    // R7 busy window mid-sequence discards the match
    rd(13'h0000, REQ_NONE, "R7");
    rd(13'h1555, REQ_NONE, "R7");
    rd(13'h0AAA, REQ_NONE, "R7");
    idle(2, 1'b1, 1'b0);
    rd(13'h1FFF, REQ_NONE, "R7");
    rd(13'h10F0, REQ_NONE, "R7");
    rd(13'h0F0F, REQ_NONE, "R7");
    // R7 busy on the sixth read
    prefix5("R7");
    access(13'h0F0F, 1'b0, 1'b1, 1'b0, REQ_NONE, "R7");
    // R8 inhibit on the sixth read and mid-sequence
    prefix5("R8");
    access(13'h0F0E, 1'b0, 1'b0, 1'b1, REQ_NONE, "R8");
    rd(13'h0000, REQ_NONE, "R8");
    rd(13'h1555, REQ_NONE, "R8");
    access(13'h0AAA, 1'b0, 1'b0, 1'b1, REQ_NONE, "R8");
    rd(13'h1FFF, REQ_NONE, "R8");
    rd(13'h10F0, REQ_NONE, "R8");
    rd(13'h0F0E, REQ_NONE, "R8");

    // R9 long gaps between steps
    rd(13'h0000, REQ_NONE, "R9");
    idle(7, 1'b0, 1'b0);
    rd(13'h1555, REQ_NONE, "R9");
    rd(13'h0AAA, REQ_NONE, "R9");
    idle(20, 1'b0, 1'b0);
    rd(13'h1FFF, REQ_NONE, "R9");
    rd(13'h10F0, REQ_NONE, "R9");
    idle(3, 1'b0, 1'b0);
    rd(13'h0F0F, REQ_STORE, "R9");

    idle(4, 1'b0, 1'b0);
    run_mon = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule